// File: doc/BRIEF.md
# Field Memory Read Timing Controller

This controller sits between a vertical reconstruction datapath and a pair of external field memories (memory A and memory B). It runs on the double-rate pixel clock. From two mode bits it selects one of four operating modes, and it places the read-enable, output-enable and read-pointer-reset strobes for both memories at fixed clock offsets from the horizontal reference. It also marks the clock where reconstructed output data becomes valid. The even/odd field flag is delayed by one field, so that it describes the field being read rather than the field being written.

Mode and field flag are captured only on the rising edge of the vertical reference. A line counter restarts on each rising edge of the horizontal reference and counts double-rate clocks; it also yields a half-rate tick. A window state machine has the states `ST_IDLE` (no reference seen yet), `ST_ARMED` (waiting for the start offset) and `ST_READ` (strobes open). Its transitions are:
- `ST_IDLE` to `ST_ARMED` on the first horizontal reference.
- `ST_ARMED` to `ST_READ` when the counter reaches the start offset of the current mode.
- `ST_READ` to `ST_ARMED` after the fixed read length.

In the multi-picture bypass mode, memory B stays idle. Memory A reads late in the line and receives a per-line read reset, so that the total delay is one line.

Top module: `fm_read_timer`

## Requirements
- R1: On a rising vertical reference edge, `mode_o` takes the value {film_in, interp_in}. The encodings are 0 = standard bypass, 1 = camera interpolation, 2 = multi-picture bypass and 3 = film interpolation. The new value shows in the cycle after that edge.
- R2: Changes on `interp_in`/`film_in` between vertical reference edges have no effect on `mode_o` or on strobe timing.
- R3: In modes 0, 1 and 3, `rd_en_a` rises 127 clocks after the clock edge that samples the horizontal reference rising. It stays high for exactly 1680 clocks.
- R4: `out_en_a` rises and falls one clock after `rd_en_a`.
- R5: `data_valid` follows `out_en_a` with a delay that depends on the mode. The delay is 32 clocks in modes 1 and 3, so the first valid clock is 160 after the reference (80 half-rate periods). It is 4 clocks in mode 0. In mode 2 it is 7 clocks, so the first valid clock is exactly one line (2048 clocks) after the reference.
- R6: In mode 2, `rd_rst` gives a one-clock pulse 2016 clocks after the reference. `rd_en_a` opens 2040 clocks after the reference for 1680 clocks.
- R7: In modes 0, 1 and 3, `rd_rst` gives a one-clock pulse in the cycle after the rising vertical reference edge. In mode 2 there is no such pulse.
- R8: Outside mode 2, `rd_en_b`/`out_en_b` equal `rd_en_a`/`out_en_a`. In mode 2 both stay low.
- R9: `even_o` carries the `even_in` value that was sampled at the previous rising vertical reference edge.
- R10: During and after reset, all strobes, `data_valid`, `slow_tick`, `even_o` and `mode_o` are 0.
- R11: `slow_tick` is 0 until the first horizontal reference. After that it is 1 on the clock whose count since the reference is even, starting with 1 at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| href | input | 1 | Horizontal reference, rising edge starts a line |
| vref | input | 1 | Vertical reference, rising edge starts a field |
| interp_in | input | 1 | Interpolation request bit |
| film_in | input | 1 | Film / multi-picture bit |
| even_in | input | 1 | Even-field flag of the field being written |
| mode_o | output | 2 | Current operating mode |
| even_o | output | 1 | Even-field flag of the field being read |
| slow_tick | output | 1 | Half-rate enable aligned to the line |
| rd_en_a | output | 1 | Read enable, memory A |
| rd_en_b | output | 1 | Read enable, memory B |
| out_en_a | output | 1 | Output enable, memory A |
| out_en_b | output | 1 | Output enable, memory B |
| rd_rst | output | 1 | Read pointer reset for both memories |
| data_valid | output | 1 | Reconstructed output data valid |

## Verification
The checker assumes that the vertical reference rises only while no read window is open. A mode switch inside a window would make memory B's strobes jump between mirroring memory A and staying idle. The stimulus therefore waits well past the end of the last read window of a field before it pulses the vertical reference. It also assumes horizontal references 2048 clocks apart, so that a multi-picture window, which spills into the next line, ends before the next start offset. The bench drives exactly that line length. Mode bits are flipped inside a field only to show that they are ignored.

// File: rtl/fmrt_pkg.sv
package fmrt_pkg;

    typedef enum logic [1:0] {
        MODE_STD  = 2'b00,
        MODE_CAM  = 2'b01,
        MODE_MPIP = 2'b10,
        MODE_FILM = 2'b11
    } op_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_READ  = 2'd2
    } win_state_t;

endpackage

// File: rtl/fmrt_field_ctl.sv
module fmrt_field_ctl
    import fmrt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     vref,
    input  logic     interp_in,
    input  logic     film_in,
    input  logic     even_in,
    output op_mode_t mode,
    output logic     even_o,
    output logic     fld_rst
);
    logic     vref_d;
    logic     even_pend;
    logic     vref_rise;
    op_mode_t mode_in;

    assign mode_in   = op_mode_t'({film_in, interp_in});
    assign vref_rise = vref & ~vref_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vref_d    <= 1'b0;
            mode      <= MODE_STD;
            even_pend <= 1'b0;
            even_o    <= 1'b0;
            fld_rst   <= 1'b0;
        end else begin
            vref_d  <= vref;
            fld_rst <= vref_rise && (mode_in != MODE_MPIP);
            if (vref_rise) begin
                mode      <= mode_in;
                even_pend <= even_in;
                even_o    <= even_pend;
            end
        end
    end
endmodule

// File: rtl/fmrt_line_timer.sv
module fmrt_line_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             href,
    output logic [CNT_W-1:0] cnt,
    output logic             armed
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic href_d;
    logic href_rise;

    assign href_rise = href & ~href_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            href_d <= 1'b0;
            cnt    <= '0;
            armed  <= 1'b0;
        end else begin
            href_d <= href;
            if (href_rise) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (armed && cnt != CNT_TOP) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fmrt_window_fsm.sv
module fmrt_window_fsm
    import fmrt_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int RD_START   = 127,
    parameter int RD_LEN     = 1680,
    parameter int MP_RST_OFS = 2016,
    parameter int MP_RD_OFS  = 2040,
    parameter int IP_DLY     = 32,
    parameter int BP_DLY     = 4,
    parameter int MP_DLY     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_mode_t         mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             armed,
    output logic             re_a,
    output logic             re_b,
    output logic             oe_a,
    output logic             oe_b,
    output logic             dv,
    output logic             mp_rst
);
    localparam int DLY_AB  = (IP_DLY > BP_DLY) ? IP_DLY : BP_DLY;
    localparam int DLY_MAX = (DLY_AB > MP_DLY) ? DLY_AB : MP_DLY;
    localparam int LEN_W   = $clog2(RD_LEN + 1);
    localparam logic [CNT_W-1:0] NRM_GO  = CNT_W'(RD_START - 1);
    localparam logic [CNT_W-1:0] MP_GO   = CNT_W'(MP_RD_OFS - 1);
    localparam logic [CNT_W-1:0] MP_HIT  = CNT_W'(MP_RST_OFS - 1);
    localparam logic [LEN_W-1:0] LEN_END = LEN_W'(RD_LEN - 1);

    win_state_t         state, nxt;
    logic [LEN_W-1:0]   len;
    logic               oe_q;
    logic [DLY_MAX-1:0] sr;
    logic [CNT_W-1:0]   go_at;
    logic               is_mp;

    assign is_mp = (mode == MODE_MPIP);
    assign go_at = is_mp ? MP_GO : NRM_GO;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (armed) nxt = ST_ARMED;
            ST_ARMED: if (cnt == go_at) nxt = ST_READ;
            ST_READ:  if (len == LEN_END) nxt = ST_ARMED;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // window length, output-enable lag, valid delay line, line reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len    <= '0;
            oe_q   <= 1'b0;
            sr     <= '0;
            mp_rst <= 1'b0;
        end else begin
            len    <= (state == ST_READ) ? len + 1'b1 : '0;
            oe_q   <= (state == ST_READ);
            sr     <= {sr[DLY_MAX-2:0], oe_q};
            mp_rst <= is_mp && armed && (cnt == MP_HIT);
        end
    end

    // outputs
    always_comb begin
        re_a = (state == ST_READ);
        re_b = re_a && !is_mp;
        oe_a = oe_q;
        oe_b = oe_q && !is_mp;
        unique case (mode)
            MODE_CAM, MODE_FILM: dv = sr[IP_DLY-1];
            MODE_STD:            dv = sr[BP_DLY-1];
            MODE_MPIP:           dv = sr[MP_DLY-1];
            default:             dv = 1'b0;
        endcase
    end
endmodule

// File: rtl/fm_read_timer.sv
module fm_read_timer
    import fmrt_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int LINE_LEN   = 2048,
    parameter int RD_START   = 127,
    parameter int RD_LEN     = 1680,
    parameter int MP_RST_OFS = 2016,
    parameter int MP_RD_OFS  = 2040,
    parameter int IP_DLY     = 32,
    parameter int BP_DLY     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       href,
    input  logic       vref,
    input  logic       interp_in,
    input  logic       film_in,
    input  logic       even_in,
    output logic [1:0] mode_o,
    output logic       even_o,
    output logic       slow_tick,
    output logic       rd_en_a,
    output logic       rd_en_b,
    output logic       out_en_a,
    output logic       out_en_b,
    output logic       rd_rst,
    output logic       data_valid
);
    localparam int MP_DLY = LINE_LEN - MP_RD_OFS - 1;

    op_mode_t         mode;
    logic             fld_rst;
    logic             mp_rst;
    logic [CNT_W-1:0] cnt;
    logic             armed;

    fmrt_field_ctl u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .vref      (vref),
        .interp_in (interp_in),
        .film_in   (film_in),
        .even_in   (even_in),
        .mode      (mode),
        .even_o    (even_o),
        .fld_rst   (fld_rst)
    );

    fmrt_line_timer #(.CNT_W(CNT_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .href  (href),
        .cnt   (cnt),
        .armed (armed)
    );

    fmrt_window_fsm #(
        .CNT_W      (CNT_W),
        .RD_START   (RD_START),
        .RD_LEN     (RD_LEN),
        .MP_RST_OFS (MP_RST_OFS),
        .MP_RD_OFS  (MP_RD_OFS),
        .IP_DLY     (IP_DLY),
        .BP_DLY     (BP_DLY),
        .MP_DLY     (MP_DLY)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .cnt    (cnt),
        .armed  (armed),
        .re_a   (rd_en_a),
        .re_b   (rd_en_b),
        .oe_a   (out_en_a),
        .oe_b   (out_en_b),
        .dv     (data_valid),
        .mp_rst (mp_rst)
    );

    assign mode_o    = mode;
    assign rd_rst    = fld_rst | mp_rst;
    assign slow_tick = armed & ~cnt[0];
endmodule

// File: rtl/fmrt_checker.sv
module fmrt_checker #(
    parameter int RD_LEN = 1680
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vref,
    input logic [1:0] mode_o,
    input logic       rd_en_a,
    input logic       rd_en_b,
    input logic       out_en_a,
    input logic       out_en_b,
    input logic       rd_rst
);
    logic        vref_q;
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vref_q <= 1'b0;
            run    <= '0;
        end else begin
            vref_q <= vref;
            run    <= rd_en_a ? run + 1'b1 : '0;
        end
    end

    // R2: mode only moves after a sampled vertical reference rise
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(vref && !vref_q) |=> $stable(mode_o));

    // R3 / R6: every read window lasts exactly RD_LEN clocks
    assert_read_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_en_a) |-> (run == 16'(RD_LEN)));

    // R4: output enable trails read enable by one clock
    assert_oe_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en_a) |=> $rose(out_en_a));

    assert_oe_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_en_a) |=> $fell(out_en_a));

    // R6 / R7: read reset is a single-clock pulse
    assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rst |=> !rd_rst);

    // R8: memory B mirrors memory A outside multi-picture mode
    assert_b_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd2) |-> (rd_en_b == rd_en_a && out_en_b == out_en_a));

    // R8: memory B idle in multi-picture mode
    assert_b_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!rd_en_b && !out_en_b));
endmodule

bind fm_read_timer fmrt_checker #(.RD_LEN(RD_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vref     (vref),
    .mode_o   (mode_o),
    .rd_en_a  (rd_en_a),
    .rd_en_b  (rd_en_b),
    .out_en_a (out_en_a),
    .out_en_b (out_en_b),
    .rd_rst   (rd_rst)
);

// File: tb/test_fm_read_timer.sv
module test_fm_read_timer;
    localparam int CLK_PERIOD = 10;
    localparam int LINE       = 2048;
    localparam int LIMIT      = 150000;

    localparam int K_RE_UP = 0, K_OE_UP = 1, K_DV_UP = 2, K_RST = 3, K_RE_DN = 4;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic href = 1'b0, vref = 1'b0;
    logic interp_in = 1'b0, film_in = 1'b0, even_in = 1'b0;
    logic [1:0] mode_o;
    logic even_o, slow_tick, rd_en_a, rd_en_b, out_en_a, out_en_b, rd_rst, data_valid;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   mirror_err = 0;
    bit   prev_even = 1'b0;
    bit   done = 1'b0;
    ev_t  q[$];
    logic p_re = 0, p_oe = 0, p_dv = 0, p_rst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fm_read_timer i_fm_read_timer (
        .clk(clk), .rst_n(rst_n), .href(href), .vref(vref),
        .interp_in(interp_in), .film_in(film_in), .even_in(even_in),
        .mode_o(mode_o), .even_o(even_o), .slow_tick(slow_tick),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en_a(out_en_a),
        .out_en_b(out_en_b), .rd_rst(rd_rst), .data_valid(data_valid)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int kind, int at, string req);
        ev_t e;
        e.kind = kind; e.at = at; e.req = req;
        q.push_back(e);
    endtask

    task automatic take(int kind);
        ev_t e;
        if (q.size() == 0) begin
            check(1'b0, "R3", $sformatf("unexpected event kind %0d at cycle", kind), cyc, -1);
        end else begin
            e = q.pop_front();
            check(e.kind == kind, e.req, "event kind", kind, e.kind);
            check(e.at == cyc, e.req, $sformatf("event %0d cycle", e.kind), cyc, e.at);
        end
    endtask

    // monitor: pops expected events as edges appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_rst && !p_rst)        take(K_RST);
            if (rd_en_a && !p_re)        take(K_RE_UP);
            if (!rd_en_a && p_re)        take(K_RE_DN);
            if (out_en_a && !p_oe)       take(K_OE_UP);
            if (data_valid && !p_dv)     take(K_DV_UP);
            if (mode_o == 2'd2) begin
                if (rd_en_b || out_en_b) mirror_err++;
            end else if (rd_en_b !== rd_en_a || out_en_b !== out_en_a) begin
                mirror_err++;
            end
        end
        p_re = rd_en_a; p_oe = out_en_a; p_dv = data_valid; p_rst = rd_rst;
    end

    task automatic push_line(int h, bit ip, bit fm);
        if (!ip && fm) begin
            push(K_RST,   h + 2016, "R6");
            push(K_RE_UP, h + 2040, "R6");
            push(K_OE_UP, h + 2041, "R4");
            push(K_DV_UP, h + 2048, "R5");
            push(K_RE_DN, h + 3720, "R6");
        end else begin
            push(K_RE_UP, h + 127,  "R3");
            push(K_OE_UP, h + 128,  "R4");
            push(K_DV_UP, h + 128 + (ip ? 32 : 4), "R5");
            push(K_RE_DN, h + 1807, "R3");
        end
    endtask

    task automatic run_field(bit ip, bit fm, bit ev, int nlines, bit poke);
        int h;
        @(negedge clk);
        interp_in = ip; film_in = fm; even_in = ev; vref = 1'b1;
        if (!(!ip && fm)) push(K_RST, cyc + 1, "R7");
        @(negedge clk);
        vref = 1'b0;
        check(mode_o == {fm, ip}, "R1", "mode after vref", mode_o, {fm, ip});
        check(even_o == prev_even, "R9", "retimed even flag", even_o, prev_even);
        prev_even = ev;
        mirror_err = 0;
        repeat (6) @(negedge clk);
        for (int l = 0; l < nlines; l++) begin
            @(negedge clk);
            href = 1'b1;
            h = cyc + 1;
            push_line(h, ip, fm);
            @(negedge clk);
            check(slow_tick == 1'b1, "R11", "tick at count 0", slow_tick, 1);
            @(negedge clk);
            check(slow_tick == 1'b0, "R11", "tick at count 1", slow_tick, 0);
            if (poke && l == 0) begin
                interp_in = ~ip; film_in = ~fm;
            end
            repeat (125) @(negedge clk);
            href = 1'b0;
            if (poke && l == 0)
                check(mode_o == {fm, ip}, "R2", "mode held mid-field", mode_o, {fm, ip});
            repeat (LINE - 128) @(negedge clk);
        end
        repeat (1800) @(negedge clk);
        if (poke) check(mode_o == {fm, ip}, "R2", "mode held to field end", mode_o, {fm, ip});
        interp_in = ip; film_in = fm;
        check(mirror_err == 0, "R8", "memory B strobe errors", mirror_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check({rd_en_a, rd_en_b, out_en_a, out_en_b, rd_rst, data_valid} == 6'b0,
              "R10", "strobes in reset", {rd_en_a, rd_en_b, out_en_a, out_en_b, rd_rst, data_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mode_o == 2'd0, "R10", "mode after reset", mode_o, 0);
        check(even_o == 1'b0, "R10", "even after reset", even_o, 0);
        check(slow_tick == 1'b0, "R11", "tick before reference", slow_tick, 0);
        check(rd_en_a == 1'b0 && data_valid == 1'b0, "R10", "idle strobes", rd_en_a, 0);

        run_field(1'b1, 1'b0, 1'b1, 3, 1'b1);   // camera, with ignored pokes
        run_field(1'b0, 1'b0, 1'b0, 2, 1'b0);   // standard bypass
        run_field(1'b0, 1'b1, 1'b1, 3, 1'b1);   // multi-picture, with ignored pokes
        run_field(1'b1, 1'b1, 1'b0, 2, 1'b0);   // film
        run_field(1'b1, 1'b0, 1'b1, 1, 1'b0);   // camera again

        check(q.size() == 0, "R5", "events left unseen", q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait (cyc >= LIMIT);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule